// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds an 8-bit control and status register whose value after a reset depends on which event caused it. Three reset events arrive: an asynchronous active-low power-on reset, a one-cycle watchdog timeout strobe and a synchronised external reset request. Each register bit is reset selectively. A bit can therefore survive some resets and be forced by others, and firmware can read the register after start-up to find out why the system restarted.

The register holds a power-on flag, a power-fail flag, a watchdog-reset flag and a watchdog reset enable bit. The enable bit is driven out to the watchdog logic. A power-fail detect strobe sets the power-fail flag. The CPU reaches the register through a write strobe with write data and a read bus that always shows the current value. The block also combines the three reset events into a single system reset output. That output is stretched to a minimum length and is released on a clock edge.

Top module: `rst_cause_reg`

## Requirements
- R1: Bit 6 is the power-on flag. Only the power-on reset sets it. Watchdog or external events and software writes never set it, and writing 0 to it clears it.
- R2: Bit 4 is the power-fail flag. A power-fail strobe sets it on the next clock edge, and power-on reset clears it. Software may write it. A strobe in the same cycle as a write of 0 leaves the bit at 1.
- R3: Bit 2 is the watchdog-reset flag. A watchdog event sets it, and power-on reset clears it. Software can only clear it, by writing 0.
- R4: Bit 1 is the watchdog reset enable and is driven on `wdt_rst_en`. Power-on reset clears it. Watchdog and external events leave it unchanged, and software may write it.
- R5: While the power-on reset is active, `rd_data` reads exactly 8'h40. `rd_data` always shows the register contents.
- R6: After the clock edge that samples a watchdog event, bits 7, 5, 3 and 0 read 0 and bit 2 reads 1. Bits 6, 4 and 1 keep their values, except that bit 4 is set if a power-fail strobe arrives in the same cycle. A write in the same cycle is ignored.
- R7: After the clock edge that samples an external event with no watchdog event, bits 7, 5, 3 and 0 read 0. Bits 6, 4, 2 and 1 keep their values, again with the power-fail strobe able to set bit 4. A write in the same cycle is ignored.
- R8: When the power-on reset is active together with other reset events, the power-on value wins.
- R9: `sys_rst_n` is low while power-on reset is active. It stays low until STRETCH_CYC clock edges after power-on release, or after the last sampled watchdog or external event. It rises only on a clock edge. STRETCH_CYC must be at least 2.
- R10: When no reset event is sampled, a write loads bits 7, 5, 4, 3, 1 and 0 with the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wdt_rst_evt | input | 1 | Watchdog timeout reset event, one-cycle strobe |
| ext_rst_evt | input | 1 | External reset request, already synchronised |
| pfail_stb | input | 1 | Power-fail detect strobe |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register value |
| wdt_rst_en | output | 1 | Watchdog reset enable (bit 1) |
| sys_rst_n | output | 1 | Merged system reset, active low |

## Verification
The assertions assume three things about the inputs. The watchdog and external events and the power-fail strobe are synchronous to `clk`. The power-on reset is the only asynchronous input. Every input is meaningless while `por_n` is low. To stay within these assumptions, the stimulus changes all synchronous inputs only on falling clock edges and toggles `por_n` away from rising edges. Random event rates are kept low so that write-only cycles, single events and coincident events all occur, and directed cases cover a power-on reset that arrives together with a watchdog event.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned RC_W = 8;

  // bit positions the watchdog logic and firmware depend on
  localparam int unsigned BIT_WEN  = 1;
  localparam int unsigned BIT_WDF  = 2;
  localparam int unsigned BIT_PFF  = 4;
  localparam int unsigned BIT_PONF = 6;

  localparam logic [RC_W-1:0] RC_POR_VAL     = 8'b0100_0000;
  // bits that survive a watchdog or external event
  localparam logic [RC_W-1:0] RC_KEEP_ON_RST = 8'b0101_0110;
  // bits that software can only clear
  localparam logic [RC_W-1:0] RC_CLR_ONLY    = 8'b0100_0100;

  typedef struct packed {
    logic wdt;
    logic ext;
    logic pf;
    logic wr;
  } rc_evt_t;
endpackage

// File: rtl/rcs_flags.sv
module rcs_flags
  import rcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  rc_evt_t         evt,
  input  logic [RC_W-1:0] wr_data,
  output logic [RC_W-1:0] q
);
  logic [RC_W-1:0] d;
  logic            any_rst;
  logic            en;

  assign any_rst = evt.wdt | evt.ext;
  assign en      = any_rst | evt.wr | evt.pf;

  for (genvar b = 0; b < RC_W; b++) begin : g_bit
    logic nb;
    always_comb begin
      nb = q[b];
      if (any_rst) begin
        if (!RC_KEEP_ON_RST[b])           nb = 1'b0;
        else if (b == BIT_WDF && evt.wdt) nb = 1'b1;
      end else if (evt.wr) begin
        if (RC_CLR_ONLY[b]) nb = q[b] & wr_data[b];
        else                nb = wr_data[b];
      end
      if (b == BIT_PFF && evt.pf) nb = 1'b1;
    end
    assign d[b] = nb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RC_POR_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/rcs_stretch.sv
module rcs_stretch #(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic out_n
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig)               cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    out_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
      out_n <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_n <= out_d;
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            wdt_rst_evt,
  input  logic            ext_rst_evt,
  input  logic            pfail_stb,
  input  logic            wr_en,
  input  logic [RC_W-1:0] wr_data,
  output logic [RC_W-1:0] rd_data,
  output logic            wdt_rst_en,
  output logic            sys_rst_n
);
  rc_evt_t         evt;
  logic [RC_W-1:0] csr_q;

  assign evt.wdt = wdt_rst_evt;
  assign evt.ext = ext_rst_evt;
  assign evt.pf  = pfail_stb;
  assign evt.wr  = wr_en;

  rcs_flags u_flags (
    .clk     (clk),
    .rst_n   (por_n),
    .evt     (evt),
    .wr_data (wr_data),
    .q       (csr_q)
  );

  rcs_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk   (clk),
    .rst_n (por_n),
    .trig  (wdt_rst_evt | ext_rst_evt),
    .out_n (sys_rst_n)
  );

  assign rd_data    = csr_q;
  assign wdt_rst_en = csr_q[BIT_WEN];
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wdt_rst_evt,
  input logic       ext_rst_evt,
  input logic       pfail_stb,
  input logic [7:0] rd_data,
  input logic       sys_rst_n
);
  AST_PON_NEVER_SET: assert property (@(posedge clk) disable iff (!por_n)
    !rd_data[6] |=> !rd_data[6]); // R1
  AST_PF_SETS: assert property (@(posedge clk) disable iff (!por_n)
    pfail_stb |=> rd_data[4]); // R2
  AST_WDT_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_evt |=> rd_data[2]); // R3
  AST_EN_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_rst_evt || ext_rst_evt) |=> rd_data[1] == $past(rd_data[1])); // R4
  AST_WDT_CLR_LOW: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst_evt |=> (rd_data[7] | rd_data[5] | rd_data[3] | rd_data[0]) == 1'b0); // R6
  AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!por_n)
    (ext_rst_evt && !wdt_rst_evt && !pfail_stb) |=>
      (rd_data[6] == $past(rd_data[6])) && (rd_data[4] == $past(rd_data[4])) &&
      (rd_data[2] == $past(rd_data[2])) &&
      (rd_data[7] | rd_data[5] | rd_data[3] | rd_data[0]) == 1'b0); // R7
  AST_SYSRST_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_rst_evt || ext_rst_evt) |=> !sys_rst_n); // R9
  AST_SYSRST_MIN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> !$past(sys_rst_n, 2)); // R9
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .wdt_rst_evt (wdt_rst_evt),
  .ext_rst_evt (ext_rst_evt),
  .pfail_stb   (pfail_stb),
  .rd_data     (rd_data),
  .sys_rst_n   (sys_rst_n)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
  localparam int S = 4;

  logic clk = 1'b0;
  logic por_n, wdt, ext, pf, we;
  logic [7:0] wd;
  logic [7:0] rd;
  logic wen, srst_n;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q;
  int exp_cnt;
  logic exp_out;

  always #2 clk = ~clk;

  rst_cause_reg #(.STRETCH_CYC(S)) uut (
    .clk(clk), .por_n(por_n), .wdt_rst_evt(wdt), .ext_rst_evt(ext),
    .pfail_stb(pf), .wr_en(we), .wr_data(wd), .rd_data(rd),
    .wdt_rst_en(wen), .sys_rst_n(srst_n)
  );

  function automatic logic [7:0] model(logic [7:0] q, logic w, logic e,
                                       logic p, logic wr, logic [7:0] d);
    logic [7:0] n;
    n = q;
    if (w || e) begin
      n = q & 8'b0101_0110;
      if (w) n[2] = 1'b1;
    end else if (wr) begin
      n = (d & 8'b1011_1011) | (q & d & 8'b0100_0100);
    end
    if (p) n[4] = 1'b1;
    return n;
  endfunction

  task automatic check(string req);
    tests++;
    if (rd !== exp_q) begin
      fails++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", req, rd, exp_q);
    end
    tests++;
    if (wen !== exp_q[1]) begin
      fails++;
      $display("FAIL R4 wdt_rst_en actual=%0b expected=%0b", wen, exp_q[1]);
    end
    tests++;
    if (srst_n !== exp_out) begin
      fails++;
      $display("FAIL R9 sys_rst_n actual=%0b expected=%0b", srst_n, exp_out);
    end
  endtask

  // called at a negedge: drive, clock once, update model, check at next negedge
  task automatic cyc(logic w, logic e, logic p, logic wr, logic [7:0] d, string req);
    wdt = w; ext = e; pf = p; we = wr; wd = d;
    @(posedge clk);
    exp_q = model(exp_q, w, e, p, wr, d);
    if (w || e) exp_cnt = S;
    else if (exp_cnt > 0) exp_cnt--;
    exp_out = (exp_cnt == 0);
    @(negedge clk);
    check(req);
  endtask

  task automatic por(logic with_wdt, string req);
    wdt = with_wdt; ext = with_wdt; pf = with_wdt; we = 1'b1; wd = 8'hFF;
    #0.5 por_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_q = 8'h40; exp_cnt = S; exp_out = 1'b0;
    check(req);
    wdt = 0; ext = 0; pf = 0; we = 0; wd = 8'h00;
    por_n = 1'b1;
  endtask

  initial begin
    #(4ns * 100000);
    fails++;
    $display("FAIL watchdog timeout");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    por_n = 1'b0; wdt = 0; ext = 0; pf = 0; we = 0; wd = 8'h00;
    exp_q = 8'h40; exp_cnt = S; exp_out = 1'b0;
    seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    check("R5");
    por_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 8'h00, "R9");

    cyc(0, 0, 0, 1, 8'hFF, "R10");   // expect FB: bit6 kept, bit2 not set (R1, R3)
    cyc(0, 1, 0, 0, 8'h00, "R7");    // expect 52
    cyc(1, 0, 0, 1, 8'h00, "R6");    // write ignored, expect 56
    cyc(0, 0, 1, 1, 8'h00, "R2");    // clears 6,2,1; pf wins: expect 10
    cyc(1, 0, 0, 0, 8'h00, "R3");    // expect 14
    cyc(0, 0, 0, 1, 8'h44, "R1");    // bit6 cannot be set: expect 04
    cyc(0, 0, 0, 1, 8'h02, "R4");    // enable on, flag cleared: 02
    cyc(0, 1, 0, 0, 8'h00, "R4");    // enable survives ext
    cyc(1, 0, 0, 0, 8'h00, "R4");    // enable survives wdt: 06
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 8'h00, "R9");
    por(1'b1, "R8");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 8'h00, "R9");

    for (int i = 0; i < 500; i++) begin
      logic w, e, p, wr;
      logic [7:0] d;
      string rq;
      w  = ($urandom % 16) == 0;
      e  = ($urandom % 16) == 0;
      p  = ($urandom % 12) == 0;
      wr = ($urandom % 3) == 0;
      d  = 8'($urandom);
      rq = w ? "R6" : e ? "R7" : p ? "R2" : wr ? "R10" : "R9";
      cyc(w, e, p, wr, d, rq);
      if (i == 250) por(1'b0, "R5");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule